// File: doc/BRIEF.md
# Codec Control Register File

This block keeps the 16-bit control registers of a stereo audio codec. A link controller reaches each register through a 7-bit even index carried in the command slots of the serial link. The control word for each register is decoded from a write or read strobe, an index, write data and a 2-bit codec identity. The block stores the writable fields and returns read data one clock after a read strobe. It also drives the volume, gain and power fields into the analog section and drives the pin that powers down an external amplifier.

Several indices behave in special ways. Index 00h holds no storage. A write of any value to it puts the whole file back to its defaults, and a read of it returns a fixed identity code. The power register at 26h mixes writable control bits with live ready flags from the analog blocks. Register 72h is protected: it can only be reached while the key value ABBAh sits in register 70h. When several codecs share the link, the block answers only those commands whose identity field matches its strap pins.

Top module: `codec_regfile`

## Requirements
- R1: A matching read of index 00h returns the ID_CODE parameter (default 6A90h) on rd_data, with rd_valid high, on the clock after the read strobe.
- R2: A matching write of any value to index 00h returns every register to its default, visible from the clock edge that samples the write.
- R3: After reset, 02h, 04h and 06h hold 8000h (bit 15 = mute set). The mixer gains 0Ch to 18h hold 8808h. The record gain 1Ch holds 8000h. Registers 26h, 70h and 72h hold 0000h.
- R4: A matching write stores only the writable bits of the target register and keeps the others at zero. The writable bits are 9F1Fh for 02h to 06h and 0Ch to 18h, 8F0Fh for 1Ch, FF00h for 26h, and FFFFh for 70h and 72h. A read returns the stored value one clock after the strobe, with rd_valid high.
- R5: Bit 15 of register 26h drives eapd, and a 1 drives the pin high. The pin changes at the clock edge that stores the bit.
- R6: Bits 3:0 of register 26h read back the blk_ready inputs sampled at the read strobe edge, and writes to those bits have no effect.
- R7: Register 72h can be written and read only while 70h holds ABBAh. Otherwise a read returns 0000h and a write is dropped.
- R8: Reads of any other index, odd indices included, return 0000h. Writes to such indices change no register.
- R9: A command whose cmd_cid differs from cid_strap is ignored: no rd_valid, no stored change, and no file reset on index 00h.
- R10: The record gain register accepts 0F0Fh, its 22.5 dB setting, and reads it back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cid_strap | input | 2 | Codec identity from the strap pins (00 = primary) |
| wr_stb | input | 1 | Write command strobe |
| rd_stb | input | 1 | Read command strobe |
| cmd_cid | input | 2 | Codec identity field of the command |
| cmd_idx | input | 7 | Register index of the command |
| cmd_wdata | input | 16 | Write data |
| blk_ready | input | 4 | Live ready flags of the analog blocks |
| rd_valid | output | 1 | Read data valid, one clock after a matching read |
| rd_data | output | 16 | Read data |
| master_vol | output | 16 | Register 02h |
| aux_vol | output | 16 | Register 04h |
| mono_vol | output | 16 | Register 06h |
| mix_gain | output | 112 | Registers 0Ch to 18h, register 0Ch in bits 15:0 |
| rec_gain | output | 16 | Register 1Ch |
| pwr_ctl | output | 16 | Register 26h, with live ready flags in bits 3:0 |
| prot_reg | output | 16 | Register 72h |
| eapd | output | 1 | External amplifier power-down pin |

## Verification
A bad stored bit shows on the matching field output at the same edge as the write that caused it. It also shows on rd_data one clock after the next read of that index. A wrong lock state makes the next read of 72h return data that should be zero, or zero where data is expected. A missed or spurious file reset shows at once on the volume outputs, which should all return to the muted default. An identity decode error shows either as a rd_valid pulse for a foreign command or as a change to a field that should have been left alone.

// File: rtl/codec_reg_pkg.sv
// Shared constants and per-slot tables for the codec control register file.
// Assumes indices are 7-bit even addresses; slot order is internal only.
package codec_reg_pkg;
    localparam int DW       = 16;
    localparam int AW       = 7;
    localparam int NREG     = 14;
    localparam int NMIX     = 7;
    localparam int SLOT_MIX0 = 3;
    localparam int SLOT_REC  = 10;
    localparam int SLOT_PWR  = 11;
    localparam int SLOT_KEY  = 12;
    localparam int SLOT_PROT = 13;
    localparam logic [AW-1:0] IDX_RESET = 7'h00;
    localparam logic [AW-1:0] IDX_PWR   = 7'h26;
    localparam logic [AW-1:0] IDX_PROT  = 7'h72;
    localparam logic [DW-1:0] UNLOCK_KEY = 16'hABBA;
    localparam int NSTAT = 4;

    // Index decoded by each storage slot.
    function automatic logic [AW-1:0] slot_idx(input int s);
        if (s < SLOT_MIX0)      slot_idx = AW'(7'h02 + 2*s);
        else if (s < SLOT_REC)  slot_idx = AW'(7'h0C + 2*(s - SLOT_MIX0));
        else if (s == SLOT_REC) slot_idx = 7'h1C;
        else if (s == SLOT_PWR) slot_idx = IDX_PWR;
        else if (s == SLOT_KEY) slot_idx = 7'h70;
        else                    slot_idx = IDX_PROT;
    endfunction

    // Value loaded by reset or by a write to index 00h.
    function automatic logic [DW-1:0] slot_def(input int s);
        if (s < SLOT_MIX0)      slot_def = 16'h8000;
        else if (s < SLOT_REC)  slot_def = 16'h8808;
        else if (s == SLOT_REC) slot_def = 16'h8000;
        else                    slot_def = 16'h0000;
    endfunction

    // Bits a write may change.
    function automatic logic [DW-1:0] slot_mask(input int s);
        if (s < SLOT_REC)       slot_mask = 16'h9F1F;
        else if (s == SLOT_REC) slot_mask = 16'h8F0F;
        else if (s == SLOT_PWR) slot_mask = 16'hFF00;
        else                    slot_mask = 16'hFFFF;
    endfunction
endpackage

// File: rtl/codec_reg_cell.sv
// One control register: loads its default on reset or file reset and
// takes masked write data on a write enable. Assumes soft_rst and we
// are never both active for the same cell in a cycle.
module codec_reg_cell #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    DEF  = '0,
    parameter logic [W-1:0]    MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Storage with default load and masked update.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            q <= DEF;
        else if (we)
            q <= (q & ~MASK) | (wdata & MASK);
    end

    AST_FILE_RESET_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> q == DEF); // R2
    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(we) && !$past(soft_rst) && $past(rst_n)) |-> $stable(q)); // R8
endmodule

// File: rtl/codec_reg_rdmux.sv
// Read path: selects the addressed register, identity code, live status
// bits or zero, and registers the result with a valid flag.
// Assumes rd_en is already qualified by the codec identity match.
module codec_reg_rdmux
    import codec_reg_pkg::*;
#(
    parameter logic [DW-1:0] ID_CODE = 16'h6A90
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [AW-1:0]      idx,
    input  logic               unlocked,
    input  logic [NSTAT-1:0]   status,
    input  logic [NREG*DW-1:0] regs,
    output logic               rd_valid,
    output logic [DW-1:0]      rd_data
);
    logic [DW-1:0] sel;

    // Combinational selection of the read value.
    always_comb begin
        sel = '0;
        if (idx == IDX_RESET) sel = ID_CODE;
        for (int s = 0; s < NREG; s++) begin
            if (idx == slot_idx(s)) begin
                sel = regs[s*DW +: DW];
                if (s == SLOT_PWR)  sel[NSTAT-1:0] = status;
                if (s == SLOT_PROT && !unlocked) sel = '0;
            end
        end
    end

    // Registered read return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= sel;
        end
    end

    AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && idx == IDX_RESET) |-> rd_data == ID_CODE); // R1
    AST_LOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && idx == IDX_PROT && !unlocked) |-> rd_data == '0); // R7
    AST_ODD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && idx[0]) |-> rd_data == '0); // R8
endmodule

// File: rtl/codec_regfile.sv
// Codec control register file top: decodes identity-matched commands,
// handles file reset via index 00h, the key lock on 72h, and drives
// the field outputs and the amplifier power-down pin.
// Assumes wr_stb and rd_stb are single-cycle command strobes.
module codec_regfile
    import codec_reg_pkg::*;
#(
    parameter logic [DW-1:0] ID_CODE = 16'h6A90
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cid_strap,
    input  logic                 wr_stb,
    input  logic                 rd_stb,
    input  logic [1:0]           cmd_cid,
    input  logic [AW-1:0]        cmd_idx,
    input  logic [DW-1:0]        cmd_wdata,
    input  logic [NSTAT-1:0]     blk_ready,
    output logic                 rd_valid,
    output logic [DW-1:0]        rd_data,
    output logic [DW-1:0]        master_vol,
    output logic [DW-1:0]        aux_vol,
    output logic [DW-1:0]        mono_vol,
    output logic [NMIX*DW-1:0]   mix_gain,
    output logic [DW-1:0]        rec_gain,
    output logic [DW-1:0]        pwr_ctl,
    output logic [DW-1:0]        prot_reg,
    output logic                 eapd
);
    logic                 id_hit, wr_hit, rd_hit, soft_rst, unlocked;
    logic [NREG*DW-1:0]   regs;
    logic [NREG-1:0]      we;

    // Command qualification by codec identity.
    always_comb begin
        id_hit   = (cmd_cid == cid_strap);
        wr_hit   = wr_stb && id_hit;
        rd_hit   = rd_stb && id_hit;
        soft_rst = wr_hit && (cmd_idx == IDX_RESET);
        unlocked = (regs[SLOT_KEY*DW +: DW] == UNLOCK_KEY);
    end

    // Per-slot write enables, with the protected slot gated by the key.
    always_comb begin
        for (int s = 0; s < NREG; s++)
            we[s] = wr_hit && (cmd_idx == slot_idx(s)) &&
                    ((s != SLOT_PROT) || unlocked);
    end

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_cell
            codec_reg_cell #(
                .W    (DW),
                .DEF  (slot_def(g)),
                .MASK (slot_mask(g))
            ) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .soft_rst (soft_rst),
                .we       (we[g]),
                .wdata    (cmd_wdata),
                .q        (regs[g*DW +: DW])
            );
        end
    endgenerate

    codec_reg_rdmux #(.ID_CODE(ID_CODE)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_hit),
        .idx      (cmd_idx),
        .unlocked (unlocked),
        .status   (blk_ready),
        .regs     (regs),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // Field outputs toward the analog section.
    always_comb begin
        master_vol = regs[0*DW +: DW];
        aux_vol    = regs[1*DW +: DW];
        mono_vol   = regs[2*DW +: DW];
        mix_gain   = regs[SLOT_MIX0*DW +: NMIX*DW];
        rec_gain   = regs[SLOT_REC*DW +: DW];
        pwr_ctl    = {regs[SLOT_PWR*DW + NSTAT +: DW-NSTAT], blk_ready};
        prot_reg   = regs[SLOT_PROT*DW +: DW];
        eapd       = regs[SLOT_PWR*DW + DW-1];
    end

    AST_EAPD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_hit && cmd_idx == IDX_PWR && cmd_wdata[DW-1]) |-> eapd); // R5
    AST_EAPD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_hit && cmd_idx == IDX_PWR && !cmd_wdata[DW-1]) |-> !eapd); // R5
    AST_FOREIGN_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_stb && cmd_cid == cid_strap)); // R9
    AST_LOCKED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_stb && cmd_idx == IDX_PROT && !unlocked) |-> $stable(prot_reg)); // R7
    AST_RESET_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> master_vol == 16'h8000); // R2
endmodule

// File: tb/sim_codec_regfile.sv
module sim_codec_regfile;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cid_strap;
    logic        wr_stb, rd_stb;
    logic [1:0]  cmd_cid;
    logic [6:0]  cmd_idx;
    logic [15:0] cmd_wdata;
    logic [3:0]  blk_ready;
    logic        rd_valid;
    logic [15:0] rd_data, master_vol, aux_vol, mono_vol, rec_gain, pwr_ctl, prot_reg;
    logic [111:0] mix_gain;
    logic        eapd;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [15:0] m [0:127];

    always #2.5 clk = ~clk;

    codec_regfile u0 (.*);

    function automatic bit impl(input logic [6:0] i);
        return (i == 7'h02 || i == 7'h04 || i == 7'h06 ||
                (i >= 7'h0C && i <= 7'h18 && !i[0]) ||
                i == 7'h1C || i == 7'h26 || i == 7'h70 || i == 7'h72);
    endfunction
    function automatic logic [15:0] bdef(input logic [6:0] i);
        if (i <= 7'h06 || (i >= 7'h0C && i <= 7'h18)) return (i >= 7'h0C) ? 16'h8808 : 16'h8000;
        if (i == 7'h1C) return 16'h8000;
        return 16'h0000;
    endfunction
    function automatic logic [15:0] bmask(input logic [6:0] i);
        if (i == 7'h1C) return 16'h8F0F;
        if (i == 7'h26) return 16'hFF00;
        if (i == 7'h70 || i == 7'h72) return 16'hFFFF;
        return 16'h9F1F;
    endfunction
    function automatic logic [15:0] exp_read(input logic [6:0] i, input logic [3:0] rdy);
        if (i == 7'h00) return 16'h6A90;
        if (!impl(i)) return 16'h0000;
        if (i == 7'h72 && m[7'h70] != 16'hABBA) return 16'h0000;
        if (i == 7'h26) return {m[i][15:4], rdy};
        return m[i];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 128; i++) m[i] = impl(7'(i)) ? bdef(7'(i)) : 16'h0;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_fields(input string req);
        chk({req, " master"}, master_vol, m[7'h02]);
        chk({req, " mono"}, mono_vol, m[7'h06]);
        chk({req, " mix0C"}, mix_gain[15:0], m[7'h0C]);
        chk({req, " mix18"}, mix_gain[111:96], m[7'h18]);
        chk({req, " rec"}, rec_gain, m[7'h1C]);
        chk({req, " prot"}, prot_reg, m[7'h72]);
        chk({req, " eapd R5"}, {15'h0, eapd}, {15'h0, m[7'h26][15]});
    endtask

    // Write with model update; applied at negedge, captured at next posedge.
    task automatic do_write(input logic [1:0] cid, input logic [6:0] idx, input logic [15:0] d);
        cmd_cid = cid; cmd_idx = idx; cmd_wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        if (cid == cid_strap) begin
            if (idx == 7'h00) model_reset();
            else if (impl(idx) && !(idx == 7'h72 && m[7'h70] != 16'hABBA))
                m[idx] = (m[idx] & ~bmask(idx)) | (d & bmask(idx));
        end
        chk_fields("R4/R2/R9 fields");
    endtask

    task automatic do_read(input string req, input logic [1:0] cid, input logic [6:0] idx);
        logic [3:0] rdy;
        rdy = 4'($urandom);
        blk_ready = rdy;
        cmd_cid = cid; cmd_idx = idx; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        chk({req, " valid R9"}, {15'h0, rd_valid}, {15'h0, cid == cid_strap});
        if (cid == cid_strap) chk(req, rd_data, exp_read(idx, rdy));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; wr_stb = 0; rd_stb = 0; cmd_cid = 0; cmd_idx = 0;
        cmd_wdata = 0; blk_ready = 0; cid_strap = 2'b01;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        // R3 reset defaults
        chk_fields("R3 reset");
        chk("R3 aux", aux_vol, 16'h8000);
        do_read("R3 read 0E", 2'b01, 7'h0E);
        do_read("R1 id", 2'b01, 7'h00);
        // R4 masking, R10 record 22.5 dB
        do_write(2'b01, 7'h02, 16'hFFFF);
        chk("R4 master mask", master_vol, 16'h9F1F);
        do_write(2'b01, 7'h1C, 16'h0F0F);
        do_read("R10 rec", 2'b01, 7'h1C);
        chk("R10 rec field", rec_gain, 16'h0F0F);
        // R5 / R6
        do_write(2'b01, 7'h26, 16'h800F);
        chk("R5 eapd high", {15'h0, eapd}, 16'h1);
        do_read("R6 status", 2'b01, 7'h26);
        do_write(2'b01, 7'h26, 16'h0000);
        chk("R5 eapd low", {15'h0, eapd}, 16'h0);
        // R7 lock
        do_write(2'b01, 7'h72, 16'h1234);
        do_read("R7 locked read", 2'b01, 7'h72);
        do_write(2'b01, 7'h70, 16'hABBA);
        do_write(2'b01, 7'h72, 16'h5A5A);
        do_read("R7 unlocked read", 2'b01, 7'h72);
        do_write(2'b01, 7'h70, 16'hABBB);
        do_read("R7 relocked read", 2'b01, 7'h72);
        // R8 unimplemented and odd
        do_write(2'b01, 7'h03, 16'hFFFF);
        do_read("R8 odd", 2'b01, 7'h03);
        do_write(2'b01, 7'h40, 16'hFFFF);
        do_read("R8 unimpl", 2'b01, 7'h40);
        // R9 foreign identity, including file reset
        do_write(2'b10, 7'h04, 16'h0001);
        do_write(2'b00, 7'h00, 16'h0000);
        chk("R9 no reset", master_vol, 16'h9F1F);
        do_read("R9 foreign read", 2'b11, 7'h02);
        // R2 file reset
        do_write(2'b01, 7'h00, 16'hC3C3);
        chk("R2 master default", master_vol, 16'h8000);
        // Random mix
        for (int n = 0; n < 1500; n++) begin
            logic [6:0] idx;
            logic [1:0] cid;
            logic [15:0] d;
            idx = ($urandom % 2) ? 7'(2 * ($urandom % 60)) : 7'($urandom);
            if ($urandom % 20 == 0) idx = 7'h00;
            if ($urandom % 6 == 0) idx = ($urandom % 2) ? 7'h70 : 7'h72;
            cid = ($urandom % 5 == 0) ? 2'($urandom) : cid_strap;
            d = 16'($urandom);
            if (idx == 7'h70 && ($urandom % 2)) d = 16'hABBA;
            if ($urandom % 2) do_write(cid, idx, d);
            else do_read("R4/R7/R8 random read", cid, idx);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule